// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This peripheral keeps a 32-bit count of elapsed seconds behind a small word-addressed register bus. An external one-cycle pulse marks each second and advances the count, which wraps from all ones to zero. Software can overwrite the count through a load register. It programs an alarm value into a match register. When the count arrives at the alarm value, a sticky alarm flag is raised. The flag reaches a single level-sensitive interrupt line through a one-bit enable, and software drops it by writing anything to the acknowledge register.

The alarm flag is held by a two-state machine. In state `ALM_IDLE` the flag is low. The transition `ARM_HIT` moves it to `ALM_PENDING` when a count or match update leaves the two values equal. In `ALM_PENDING` the flag is high. The transition `ACK_CLEAR` returns it to `ALM_IDLE` on an acknowledge write, but only if no hit happens in the same cycle. A hit always takes priority over an acknowledge. The upper part of the 4 KB window holds eight fixed identification words. The control word always reports the block as running.

Reads are combinational: `bus_rdata` shows the addressed word while `bus_rd` is high and is zero otherwise. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the count, the alarm value, the interrupt enable and the alarm flag are all 0, and `irq_o` is low.
- R2: Each cycle with `tick_i` high adds 1 to the count, wrapping from 0xFFFFFFFF to 0. A read of offset 0x00 returns the live count.
- R3: A write to offset 0x08 replaces the count with the written data. A read of 0x08 returns the last value written there. A load and a tick in the same cycle leave the loaded value.
- R4: Offset 0x04 holds the alarm value and reads it back. The alarm flag (bit 0 of offset 0x14) is set at the edge where a tick makes the count equal to the alarm value. It stays set after later ticks move the count past that value.
- R5: A write to 0x04 or 0x08 that leaves the count equal to the alarm value sets the alarm flag at that same edge.
- R6: Offset 0x10 stores only bit 0 of the written data as the interrupt enable. Offset 0x18 reads the alarm flag AND the enable, and `irq_o` carries the same value.
- R7: A write of any data to offset 0x1C clears the alarm flag. If an alarm hit happens in the same cycle, the flag stays set.
- R8: Offset 0x0C always reads 1, and writes to it have no effect.
- R9: The word reads at 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R10: Writes to 0x00, 0x14 and 0x18 change nothing. A read of 0x1C returns 0, and so does a read of any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds pulse |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
Two functions can fall on the same edge: an acknowledge write to 0x1C and a tick that brings the count onto the alarm value. The bench sets the alarm value one above the current count. It then drives the acknowledge write and the tick in the same cycle. It judges the result by reading 0x14 afterwards, which must still show the flag set. A second collision, a load together with a tick, is provoked in the same way and judged by reading the count back, which must equal the loaded value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // word indices (byte offset >> 2)
    localparam logic [9:0] W_COUNT  = 10'h000;
    localparam logic [9:0] W_MATCH  = 10'h001;
    localparam logic [9:0] W_LOAD   = 10'h002;
    localparam logic [9:0] W_CTRL   = 10'h003;
    localparam logic [9:0] W_MASK   = 10'h004;
    localparam logic [9:0] W_RAW    = 10'h005;
    localparam logic [9:0] W_MASKED = 10'h006;
    localparam logic [9:0] W_ACK    = 10'h007;

    // upper address bits selecting the identification block (0xFE0..0xFFF)
    localparam logic [6:0] ID_PAGE = 7'h7F;

    typedef enum logic [0:0] {
        ALM_IDLE    = 1'b0,
        ALM_PENDING = 1'b1
    } alm_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_q,
    output logic [W-1:0] count_nxt,
    output logic         count_upd
);
    always_comb begin
        count_upd = load_en | tick;
        if (load_en)
            count_nxt = load_val;
        else if (tick)
            count_nxt = count_q + W'(1);
        else
            count_nxt = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_nxt;
    end

    AST_TICK_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (count_q == $past(count_q) + W'(1))); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count_q == $past(load_val))); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count_q)); // R2
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] count_nxt,
    input  logic [W-1:0] match_nxt,
    input  logic         ack,
    output logic         raw
);
    alm_state_t state_q, state_d;
    logic       hit;

    assign hit = upd && (count_nxt == match_nxt);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE:    if (hit) state_d = ALM_PENDING;            // ARM_HIT
            ALM_PENDING: if (ack && !hit) state_d = ALM_IDLE;       // ACK_CLEAR
            default:     state_d = ALM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ALM_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ALM_PENDING: raw = 1'b1;
            default:     raw = 1'b0;
        endcase
    end

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !ack) |=> raw); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !upd) |=> !raw); // R7
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && count_nxt == match_nxt) |=> raw); // R5
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  count_q,
    input  logic          raw,
    output logic          load_wr,
    output logic          ack_wr,
    output logic [W-1:0]  match_nxt,
    output logic [W-1:0]  bus_rdata,
    output logic          irq
);
    localparam int WA = AW - 2;

    logic [WA-1:0] word;
    logic [W-1:0]  match_q;
    logic [W-1:0]  load_shadow_q;
    logic          mask_q;
    logic          match_wr;
    logic          mask_wr;
    logic          masked;

    assign word     = bus_addr[AW-1:2];
    assign load_wr  = bus_wr && (word == W_LOAD);
    assign match_wr = bus_wr && (word == W_MATCH);
    assign mask_wr  = bus_wr && (word == W_MASK);
    assign ack_wr   = bus_wr && (word == W_ACK);

    assign match_nxt = match_wr ? bus_wdata : match_q;
    assign masked    = raw & mask_q;
    assign irq       = masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q       <= '0;
            load_shadow_q <= '0;
            mask_q        <= 1'b0;
        end else begin
            match_q <= match_nxt;
            if (load_wr)
                load_shadow_q <= bus_wdata;
            if (mask_wr)
                mask_q <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr[AW-1:5] == ID_PAGE)
                bus_rdata = W'(id_byte(bus_addr[4:2]));
            else begin
                unique case (word)
                    W_COUNT:  bus_rdata = count_q;
                    W_MATCH:  bus_rdata = match_q;
                    W_LOAD:   bus_rdata = load_shadow_q;
                    W_CTRL:   bus_rdata = W'(1);
                    W_MASK:   bus_rdata = W'(mask_q);
                    W_RAW:    bus_rdata = W'(raw);
                    W_MASKED: bus_rdata = W'(masked);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    AST_MASK_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(bus_wdata[0]))); // R6
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_wr |=> $stable(match_q)); // R4
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R10
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] count_q, count_nxt, match_nxt;
    logic              count_upd, load_wr, ack_wr, match_upd, raw;

    rtc_regs #(.W(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .count_q(count_q), .raw(raw),
        .load_wr(load_wr), .ack_wr(ack_wr), .match_nxt(match_nxt),
        .bus_rdata(bus_rdata), .irq(irq_o)
    );

    rtc_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .load_en(load_wr), .load_val(bus_wdata),
        .count_q(count_q), .count_nxt(count_nxt), .count_upd(count_upd)
    );

    assign match_upd = count_upd | (bus_wr && (bus_addr[ADDR_W-1:2] == W_MATCH));

    rtc_alarm_fsm #(.W(DATA_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .upd(match_upd),
        .count_nxt(count_nxt), .match_nxt(match_nxt),
        .ack(ack_wr), .raw(raw)
    );

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> raw); // R6
endmodule

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_cnt;

    always #4 clk = ~clk;

    rtc_alarm_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // one bus cycle, optionally with a tick in the same cycle
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_i = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_i = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        exp_cnt = exp_cnt + 32'd1;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(12'h000, v); check("R1 count", v, 0);
        bus_read(12'h004, v); check("R1 match", v, 0);
        bus_read(12'h010, v); check("R1 mask", v, 0);
        bus_read(12'h014, v); check("R1 raw", v, 0);
        check("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_tick();
        logic [31:0] v;
        bus_write(12'h004, 32'hDEAD_0000, 1'b0);
        exp_cnt = 0;
        for (int i = 0; i < 3; i++) tick_once();
        bus_read(12'h000, v); check("R2 three ticks", v, exp_cnt);
        bus_write(12'h008, 32'hFFFF_FFFF, 1'b0);
        exp_cnt = 32'hFFFF_FFFF;
        tick_once();
        bus_read(12'h000, v); check("R2 wrap", v, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        bus_write(12'h008, 32'h0000_0100, 1'b0);
        bus_read(12'h000, v); check("R3 load count", v, 32'h100);
        tick_once();
        bus_read(12'h008, v); check("R3 load shadow", v, 32'h100);
        bus_write(12'h008, 32'h0000_0200, 1'b1);
        exp_cnt = 32'h200;
        bus_read(12'h000, v); check("R3 load beats tick", v, 32'h200);
    endtask

    task automatic t_match();
        logic [31:0] v;
        bus_write(12'h01C, 0, 1'b0);
        bus_write(12'h004, exp_cnt + 32'd2, 1'b0);
        bus_read(12'h004, v); check("R4 match readback", v, exp_cnt + 32'd2);
        tick_once();
        bus_read(12'h014, v); check("R4 not yet", v, 0);
        tick_once();
        bus_read(12'h014, v); check("R4 hit", v, 1);
        tick_once();
        bus_read(12'h014, v); check("R4 sticky", v, 1);
    endtask

    task automatic t_immediate();
        logic [31:0] v;
        bus_write(12'h01C, 0, 1'b0);
        bus_write(12'h004, exp_cnt, 1'b0);
        bus_read(12'h014, v); check("R5 match write", v, 1);
        bus_write(12'h01C, 0, 1'b0);
        bus_read(12'h014, v); check("R5 cleared", v, 0);
        bus_write(12'h008, exp_cnt, 1'b0);
        bus_read(12'h014, v); check("R5 load write", v, 1);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(12'h010, 32'hFFFF_FFFE, 1'b0);
        bus_read(12'h010, v); check("R6 mask bit0 only", v, 0);
        check("R6 irq masked", 32'(irq_o), 0);
        bus_read(12'h018, v); check("R6 masked off", v, 0);
        bus_write(12'h010, 32'h0000_0003, 1'b0);
        bus_read(12'h010, v); check("R6 mask set", v, 1);
        bus_read(12'h018, v); check("R6 masked on", v, 1);
        check("R6 irq on", 32'(irq_o), 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        bus_write(12'h01C, 32'h0000_0000, 1'b0);
        bus_read(12'h014, v); check("R7 clear by zero", v, 0);
        check("R7 irq low", 32'(irq_o), 0);
        bus_write(12'h004, exp_cnt + 32'd1, 1'b0);
        bus_write(12'h01C, 32'h1234_5678, 1'b1);
        exp_cnt = exp_cnt + 32'd1;
        bus_read(12'h014, v); check("R7 hit beats clear", v, 1);
        check("R7 irq held", 32'(irq_o), 1);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        bus_read(12'h00C, v); check("R8 ctrl", v, 1);
        bus_write(12'h00C, 32'h0, 1'b0);
        bus_read(12'h00C, v); check("R8 ctrl after write", v, 1);
    endtask

    task automatic t_id();
        logic [31:0] v;
        logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), v);
            check("R9 id", v, 32'(ids[i]));
        end
    endtask

    task automatic t_ro();
        logic [31:0] v;
        bus_write(12'h000, 32'h5555_5555, 1'b0);
        bus_read(12'h000, v); check("R10 count ro", v, exp_cnt);
        bus_write(12'h014, 32'h0, 1'b0);
        bus_write(12'h018, 32'h0, 1'b0);
        bus_read(12'h014, v); check("R10 raw ro", v, 1);
        bus_read(12'h01C, v); check("R10 ack reads 0", v, 0);
        bus_read(12'h040, v); check("R10 unmapped", v, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick();
        t_load();
        t_match();
        t_immediate();
        t_mask();
        t_clear();
        t_ctrl();
        t_id();
        t_ro();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule